// File: doc/BRIEF.md
# Seven-to-One Differential Display Link Serializer

This block turns one parallel display pixel per pixel clock into serial streams for a low-voltage differential display link. A pixel has 24 colour bits, the two sync strobes, a data-enable strobe and one spare control bit, 28 lines in all. They are spread over four data lanes, each carrying 7 bits per pixel. A fifth lane sends a copy of the pixel clock. The block runs from a fast clock at exactly 3.5 times the pixel rate. Each lane sends two bits per fast cycle, so each lane drives a pair of double-data-rate output registers. The bit on the even index goes out in the first half of the fast cycle and the bit on the odd index goes out in the second half.

Seven bits do not fill a whole number of two-bit fast cycles. The serializer therefore works on a span of two pixels, which takes seven fast cycles. A state machine walks through the seven phases of that span. It fetches a new pixel at the first phase and at the fourth phase. At the fourth phase, the last bit of one pixel and the first bit of the next pixel leave in the same cycle. Pixels cross from the pixel clock domain to the fast domain through a two-entry buffer with Gray-coded pointers. Every lane has a true side and a complement side, so that a differential pair can be built from two single-ended outputs. If the buffer runs dry when a pixel is due, the block raises a sticky error flag.

States: IDLE (no data buffered, outputs at rest), PRIME (one settling cycle after data first appears), and C0 to C6 (the seven phases of a two-pixel span). Transitions: IDLE goes to PRIME when the buffer is not empty. PRIME goes to C0. C0 goes to C1 and C3 goes to C4 when the buffer holds a pixel. C0 and C3 go to IDLE, and raise the error, when the buffer is empty. C1, C2, C4 and C5 each move to the next phase, and C6 goes to C0.

Top module: `lvds7_serializer`

## Requirements
- R1: While reset is asserted and after it is released, until the first pixel is sent: lane_p reads 0, lane_n reads 8'hFF, fwd_clk_p reads 0, fwd_clk_n reads 2'b11 and underflow reads 0.
- R2: Data lane 0 sends, in time order: green bit 2, then red bits 7 down to 2. Red is pix_rgb[23:16], green is pix_rgb[15:8] and blue is pix_rgb[7:0].
- R3: Data lane 1 sends, in time order: blue bit 3, blue bit 2, then green bits 7 down to 3.
- R4: Data lane 2 sends, in time order: pix_de, pix_vsync, pix_hsync, then blue bits 7 down to 4.
- R5: Data lane 3 sends, in time order: pix_aux, blue 1, blue 0, green 1, green 0, red 1, red 0.
- R6: Lane L uses lane_p[2L] for the earlier bit and lane_p[2L+1] for the later bit of each fast cycle. Two pixels take exactly seven fast cycles, and the fourth cycle carries the last bit of the first pixel followed by the first bit of the second pixel.
- R7: Per pixel, fwd_clk_p sends the time-ordered pattern 1,1,0,0,0,1,1, which starts together with the first bit of each pixel. The pairs over a span are 11,00,10 (even index 0, odd index 1),11,01,00,11, written as {odd,even}.
- R8: In every cycle, lane_n equals the bitwise complement of lane_p and fwd_clk_n equals the complement of fwd_clk_p.
- R9: The first pixel sent is the first pixel captured after reset, or after a restart. Pixels then follow in capture order with none skipped or repeated, and the first pixel begins within 16 fast cycles of the release.
- R10: If a pixel is due (phase C0 or C3) and the buffer is empty, underflow goes to 1 and all positive-side outputs drop to 0 in that same cycle. A steady pixel stream never raises underflow.
- R11: underflow stays 1 until reset. Once pixels arrive again, streaming resumes with correct content, starting from the first new pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock; one pixel is captured per rising edge |
| clk_fast | input | 1 | Serial clock at 3.5 times the pixel rate, phase-locked to it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pix_rgb | input | 24 | Colour bits: red [23:16], green [15:8], blue [7:0] |
| pix_hsync | input | 1 | Horizontal sync |
| pix_vsync | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| pix_aux | input | 1 | Spare control bit |
| lane_p | output | 8 | True side: lane L uses bits 2L (first) and 2L+1 (second) |
| lane_n | output | 8 | Complement side of lane_p |
| fwd_clk_p | output | 2 | Forwarded clock lane, true side, bit 0 first |
| fwd_clk_n | output | 2 | Forwarded clock lane, complement side |
| underflow | output | 1 | Sticky flag: a due pixel was missing |

## Verification
The bench drives walking-one, alternating all-ones/all-zeros and hashed pixel streams. It then rebuilds each lane's 14-bit span from the captured pairs, so a swapped field, a reversed lane order or a pair whose halves are exchanged shows up as mismatches on the lane concerned. The mid-cycle pixel boundary in phase C3 gets the most attention: a design that fetched its second pixel a cycle early or late would smear bits across spans, and one that reset the span each pixel would break the 1100011 clock pattern. The pixel clock is then stopped to starve the buffer. A design that kept sending stale data, did not flag the error, or cleared the flag on restart is caught, as is one that resumed from a leftover pixel instead of the first new one.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;

    localparam int LANES     = 4;
    localparam int LANE_BITS = 7;
    localparam int PIX_W     = 28;
    localparam int PTR_W     = 2;
    localparam int PAIR_W    = 2;
    localparam int OUT_W     = LANES * PAIR_W;

    typedef logic [PIX_W-1:0]     pixel_t;
    typedef logic [LANE_BITS-1:0] lane_word_t;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PRIME = 4'd1,
        ST_C0    = 4'd2,
        ST_C1    = 4'd3,
        ST_C2    = 4'd4,
        ST_C3    = 4'd5,
        ST_C4    = 4'd6,
        ST_C5    = 4'd7,
        ST_C6    = 4'd8
    } tx_state_t;

    // Pixel packing: {aux, de, vsync, hsync, red[7:0], green[7:0], blue[7:0]}
    // Returned word: bit 0 leaves first on the wire.
    function automatic lane_word_t lane_word(input pixel_t px, input int lane);
        logic [7:0] r, g, b;
        logic       hs, vs, de, ax;
        lane_word_t w;
        r  = px[23:16];
        g  = px[15:8];
        b  = px[7:0];
        hs = px[24];
        vs = px[25];
        de = px[26];
        ax = px[27];
        case (lane)
            0:       w = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
            1:       w = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
            2:       w = {b[4], b[5], b[6], b[7], hs, vs, de};
            default: w = {r[0], r[1], g[0], g[1], b[0], b[1], ax};
        endcase
        return w;
    endfunction

    // Position of a streaming state inside the two-pixel span.
    function automatic logic [2:0] span_phase(input tx_state_t s);
        logic [2:0] k;
        unique case (s)
            ST_C1:   k = 3'd1;
            ST_C2:   k = 3'd2;
            ST_C3:   k = 3'd3;
            ST_C4:   k = 3'd4;
            ST_C5:   k = 3'd5;
            ST_C6:   k = 3'd6;
            default: k = 3'd0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/lvds7_pix_buffer.sv
module lvds7_pix_buffer
    import lvds7_pkg::*;
(
    input  logic             clk_pix,
    input  logic             rst_n,
    input  pixel_t           wr_pix,
    input  logic             rd_idx,
    output pixel_t           rd_pix,
    output logic [PTR_W-1:0] wr_gray
);

    localparam int DEPTH = 2;

    pixel_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] wr_bin_nxt;

    always_comb begin
        wr_bin_nxt = wr_bin + 1'b1;
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
        end
    end

    always_ff @(posedge clk_pix) begin
        if (rst_n) begin
            mem[wr_bin[0]] <= wr_pix;
        end
    end

    assign rd_pix = mem[rd_idx];

endmodule

// File: rtl/lvds7_sync.sv
module lvds7_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/lvds7_tx_fsm.sv
module lvds7_tx_fsm
    import lvds7_pkg::*;
#(
    parameter logic [LANE_BITS-1:0] CLK_WORD = 7'b1100011
) (
    input  logic               clk_fast,
    input  logic               rst_n,
    input  logic [PTR_W-1:0]   wr_gray_s,
    input  pixel_t             rd_pix,
    output logic               rd_idx,
    output logic [OUT_W-1:0]   lane_p,
    output logic [OUT_W-1:0]   lane_n,
    output logic [PAIR_W-1:0]  fclk_p,
    output logic [PAIR_W-1:0]  fclk_n,
    output logic               underflow
);

    localparam int SPAN_W = 2 * LANE_BITS;

    tx_state_t        state, state_nxt;
    pixel_t           hold;
    logic [PTR_W-1:0] rd_bin, rd_gray, rd_bin_nxt;
    logic             empty, fetch_phase, pop, underrun, streaming, emit;
    pixel_t           lo_pix, hi_pix;
    logic [2:0]       k;
    logic [3:0]       idx_first, idx_second;
    logic [OUT_W-1:0]  nxt_lane;
    logic [PAIR_W-1:0] nxt_fclk;
    logic [SPAN_W-1:0] clk_span;

    assign empty       = (rd_gray == wr_gray_s);
    assign fetch_phase = (state == ST_C0) || (state == ST_C3);
    assign pop         = fetch_phase && !empty;
    assign underrun    = fetch_phase && empty;
    assign streaming   = (state != ST_IDLE) && (state != ST_PRIME);
    assign emit        = streaming && !underrun;
    assign lo_pix      = (state == ST_C0) ? rd_pix : hold;
    assign hi_pix      = (state == ST_C3) ? rd_pix : hold;
    assign k           = span_phase(state);
    assign idx_first   = {k, 1'b0};
    assign idx_second  = {k, 1'b1};
    assign rd_idx      = rd_bin[0];
    assign rd_bin_nxt  = rd_bin + 1'b1;
    assign clk_span    = {CLK_WORD, CLK_WORD};

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = empty ? ST_IDLE : ST_PRIME;
            ST_PRIME: state_nxt = ST_C0;
            ST_C0:    state_nxt = empty ? ST_IDLE : ST_C1;
            ST_C1:    state_nxt = ST_C2;
            ST_C2:    state_nxt = ST_C3;
            ST_C3:    state_nxt = empty ? ST_IDLE : ST_C4;
            ST_C4:    state_nxt = ST_C5;
            ST_C5:    state_nxt = ST_C6;
            ST_C6:    state_nxt = ST_C0;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Per-lane bit selection over the two-pixel span
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [SPAN_W-1:0] span;
        assign span = {lane_word(hi_pix, L), lane_word(lo_pix, L)};
        assign nxt_lane[PAIR_W*L]     = emit & span[idx_first];
        assign nxt_lane[PAIR_W*L + 1] = emit & span[idx_second];
    end

    assign nxt_fclk[0] = emit & clk_span[idx_first];
    assign nxt_fclk[1] = emit & clk_span[idx_second];

    // Output registers
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            lane_p    <= '0;
            lane_n    <= '1;
            fclk_p    <= '0;
            fclk_n    <= '1;
            underflow <= 1'b0;
        end else begin
            lane_p <= nxt_lane;
            lane_n <= ~nxt_lane;
            fclk_p <= nxt_fclk;
            fclk_n <= ~nxt_fclk;
            if (underrun) underflow <= 1'b1;
        end
    end

    // Read pointer and held pixel
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            hold    <= '0;
        end else if (pop) begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
            hold    <= rd_pix;
        end
    end

endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer
    import lvds7_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter logic [LANE_BITS-1:0] CLK_WORD    = 7'b1100011
) (
    input  logic        clk_pix,
    input  logic        clk_fast,
    input  logic        rst_n,
    input  logic [23:0] pix_rgb,
    input  logic        pix_hsync,
    input  logic        pix_vsync,
    input  logic        pix_de,
    input  logic        pix_aux,
    output logic [7:0]  lane_p,
    output logic [7:0]  lane_n,
    output logic [1:0]  fwd_clk_p,
    output logic [1:0]  fwd_clk_n,
    output logic        underflow
);

    pixel_t           wr_pix, rd_pix;
    logic             rd_idx;
    logic [PTR_W-1:0] wr_gray, wr_gray_s;

    assign wr_pix = {pix_aux, pix_de, pix_vsync, pix_hsync, pix_rgb};

    lvds7_pix_buffer u_buf (
        .clk_pix (clk_pix),
        .rst_n   (rst_n),
        .wr_pix  (wr_pix),
        .rd_idx  (rd_idx),
        .rd_pix  (rd_pix),
        .wr_gray (wr_gray)
    );

    lvds7_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    lvds7_tx_fsm #(.CLK_WORD(CLK_WORD)) u_fsm (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .wr_gray_s (wr_gray_s),
        .rd_pix    (rd_pix),
        .rd_idx    (rd_idx),
        .lane_p    (lane_p),
        .lane_n    (lane_n),
        .fclk_p    (fwd_clk_p),
        .fclk_n    (fwd_clk_n),
        .underflow (underflow)
    );

endmodule

// File: rtl/lvds7_serializer_chk.sv
module lvds7_serializer_chk (
    input logic       clk_fast,
    input logic       rst_n,
    input logic [7:0] lane_p,
    input logic [7:0] lane_n,
    input logic [1:0] fwd_clk_p,
    input logic [1:0] fwd_clk_n,
    input logic       underflow
);

    assert_complement_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (lane_n == ~lane_p) && (fwd_clk_n == ~fwd_clk_p));

    assert_flag_sticky_R11: assert property (@(posedge clk_fast) disable iff (!rst_n)
        underflow |=> underflow);

    assert_rest_on_underflow_R10: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(underflow) |-> (lane_p == 8'h00) && (fwd_clk_p == 2'b00));

    assert_clk_fall_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fwd_clk_p == 2'b01) |=> (fwd_clk_p == 2'b00));

    assert_clk_rise_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (fwd_clk_p == 2'b10) |=> ((fwd_clk_p == 2'b11) || (fwd_clk_p == 2'b00)));

endmodule

bind lvds7_serializer lvds7_serializer_chk u_chk (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .lane_p    (lane_p),
    .lane_n    (lane_n),
    .fwd_clk_p (fwd_clk_p),
    .fwd_clk_n (fwd_clk_n),
    .underflow (underflow)
);

// File: tb/sim_lvds7_serializer.sv
module sim_lvds7_serializer;

    localparam int FAST_PERIOD = 20;
    localparam int PIX_HALF    = FAST_PERIOD * 7 / 4;
    localparam int CAP_N       = 72;
    localparam int NPIX        = 16;
    localparam logic [6:0] CLK_SEQ = 7'b1100011;
    // Source index into {aux,de,vs,hs,R,G,B}, per lane, in time order
    localparam int MAP [4][7] = '{
        '{10, 23, 22, 21, 20, 19, 18},
        '{ 3,  2, 15, 14, 13, 12, 11},
        '{26, 25, 24,  7,  6,  5,  4},
        '{27,  1,  0,  9,  8, 17, 16}
    };

    logic        clk_fast = 1'b0;
    logic        clk_pix  = 1'b0;
    logic        pix_run  = 1'b1;
    logic        rst_n    = 1'b0;
    logic [23:0] pix_rgb  = '0;
    logic        pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0, pix_aux = 1'b0;
    logic [7:0]  lane_p, lane_n;
    logic [1:0]  fwd_clk_p, fwd_clk_n;
    logic        underflow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] cap_dp [CAP_N];
    logic [7:0] cap_dn [CAP_N];
    logic [1:0] cap_cp [CAP_N];
    logic [1:0] cap_cn [CAP_N];

    lvds7_serializer u0 (
        .clk_pix(clk_pix), .clk_fast(clk_fast), .rst_n(rst_n),
        .pix_rgb(pix_rgb), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync),
        .pix_de(pix_de), .pix_aux(pix_aux),
        .lane_p(lane_p), .lane_n(lane_n),
        .fwd_clk_p(fwd_clk_p), .fwd_clk_n(fwd_clk_n), .underflow(underflow)
    );

    always #(FAST_PERIOD/2) clk_fast = ~clk_fast;
    initial forever begin
        #(PIX_HALF);
        if (pix_run) clk_pix = ~clk_pix;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [27:0] pattern(input int mode, input int k);
        logic [31:0] h;
        case (mode)
            0: return 28'h1 << (k % 28);
            1: return (k % 2 == 1) ? 28'hFFFFFFF : 28'h0;
            default: begin
                h = (k + 7) * 32'h9E3779B1;
                h = h ^ (h >> 15) ^ (k << 9);
                return h[27:0];
            end
        endcase
    endfunction

    task automatic put_pixel(input logic [27:0] v);
        {pix_aux, pix_de, pix_vsync, pix_hsync, pix_rgb} = v;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        pix_run = 1'b1;
        put_pixel('0);
        repeat (4) @(negedge clk_pix);
        @(negedge clk_fast);
        check(lane_p == 8'h00 && lane_n == 8'hFF, "R1", "data lanes at reset",
              {lane_n, lane_p}, 32'hFF00);
        check(fwd_clk_p == 2'b00 && fwd_clk_n == 2'b11 && underflow == 1'b0, "R1",
              "clock lane and flag at reset", {fwd_clk_n, fwd_clk_p, underflow}, 32'h18);
        @(negedge clk_pix);
        rst_n = 1'b1;
    endtask

    // Streams NPIX pixels (plus padding) and checks every lane's content.
    task automatic run_stream(input int mode, input bit expect_uf, input string tag);
        int s;
        int bad [4];
        int bad_clk, bad_cmp;
        logic [31:0] first_act [4];
        logic [31:0] first_exp [4];
        fork
            begin
                for (int k = 0; k < NPIX + 6; k++) begin
                    put_pixel(pattern(mode, k));
                    @(negedge clk_pix);
                end
            end
            begin
                for (int c = 0; c < CAP_N; c++) begin
                    @(negedge clk_fast);
                    cap_dp[c] = lane_p;
                    cap_dn[c] = lane_n;
                    cap_cp[c] = fwd_clk_p;
                    cap_cn[c] = fwd_clk_n;
                end
            end
        join
        s = -1;
        for (int c = 0; c < CAP_N; c++) begin
            if (s < 0 && cap_cp[c] == 2'b11) s = c;
        end
        // R9: first pixel starts promptly and in capture order
        check(s >= 0 && s <= 16, "R9", {tag, " start of first pixel"}, s, 16);
        if (s < 0 || s > 16) s = 0;
        for (int L = 0; L < 4; L++) begin
            bad[L] = 0;
            first_act[L] = 0;
            first_exp[L] = 0;
        end
        bad_clk = 0;
        bad_cmp = 0;
        for (int g = 0; g < NPIX / 2; g++) begin
            for (int t = 0; t < 14; t++) begin
                int cyc;
                int half;
                logic [27:0] px;
                cyc  = s + 7 * g + t / 2;
                half = t % 2;
                px   = pattern(mode, 2 * g + t / 7);
                for (int L = 0; L < 4; L++) begin
                    logic got, want;
                    got  = cap_dp[cyc][2 * L + half];
                    want = px[MAP[L][t % 7]];
                    if (got !== want) begin
                        if (bad[L] == 0) begin
                            first_act[L] = {g[7:0], t[7:0], 15'd0, got};
                            first_exp[L] = {g[7:0], t[7:0], 15'd0, want};
                        end
                        bad[L]++;
                    end
                end
                if (cap_cp[cyc][half] !== CLK_SEQ[t % 7]) bad_clk++;
            end
        end
        for (int c = 0; c < CAP_N; c++) begin
            if (cap_dn[c] !== ~cap_dp[c] || cap_cn[c] !== ~cap_cp[c]) bad_cmp++;
        end
        // R6 pair order and span boundary is covered by every lane check
        check(bad[0] == 0, "R2", {tag, " lane 0 order (R6 pairing)"}, first_act[0], first_exp[0]);
        check(bad[1] == 0, "R3", {tag, " lane 1 order (R6 pairing)"}, first_act[1], first_exp[1]);
        check(bad[2] == 0, "R4", {tag, " lane 2 order (R6 pairing)"}, first_act[2], first_exp[2]);
        check(bad[3] == 0, "R5", {tag, " lane 3 order (R6 pairing)"}, first_act[3], first_exp[3]);
        check(bad_clk == 0, "R7", {tag, " forwarded clock pattern mismatches"}, bad_clk, 0);
        check(bad_cmp == 0, "R8", {tag, " complement side mismatches"}, bad_cmp, 0);
        check(underflow == expect_uf, expect_uf ? "R11" : "R10",
              {tag, " underflow flag after stream"}, underflow, expect_uf);
    endtask

    task automatic test_walking_one();
        do_reset();
        run_stream(0, 1'b0, "walking-one");
    endtask

    task automatic test_alternating();
        do_reset();
        run_stream(1, 1'b0, "alternating");
    endtask

    task automatic test_hashed();
        do_reset();
        run_stream(2, 1'b0, "hashed");
    endtask

    task automatic test_underflow();
        do_reset();
        run_stream(2, 1'b0, "pre-starve");
        pix_run = 1'b0;
        repeat (30) @(negedge clk_fast);
        check(underflow == 1'b1, "R10", "flag after starving", underflow, 1);
        check(lane_p == 8'h00 && fwd_clk_p == 2'b00, "R10", "outputs at rest after starving",
              {fwd_clk_p, lane_p}, 0);
        check(lane_n == 8'hFF, "R10", "complement at rest after starving", lane_n, 8'hFF);
        pix_run = 1'b1;
        run_stream(1, 1'b1, "R11 resume");
    endtask

    initial begin
        test_walking_one();
        test_alternating();
        test_hashed();
        test_underflow();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(FAST_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule